// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block is one output cell of a programmable logic array. It receives a sum-of-products term and a second XOR term from the product-term array, and a small set of per-block control lines: four clock lines and three set/reset lines. Static configuration inputs set how the cell behaves:

- It can pass the XOR of its two terms straight through (combinatorial).
- It can store that result in an edge-triggered element (registered).
- It can hold it in a level-sensitive latch (latched).

In registered mode, a next-state stage in front of a single D flip-flop makes the element act as a D, toggle, J-K or set-reset flip-flop. The two data terms serve as the flip-flop's inputs.

Each cell picks its own clock line and its own set line and reset line from the shared control lines. A programmable inversion sets the polarity of the pin-side output. The feedback output always returns the true, uninverted stored or combinational value to the routing array.

Top module: `mc_macrocell`

## Requirements
- R1: With `cfg_mode` 0 or 3 (combinatorial), `mc_fb` equals `sop_in ^ xor_in`. Clock lines and set/reset lines have no effect on it.
- R2: With `cfg_mode` 1 (registered) and `cfg_ff_type` 0 (D), a rising edge on the selected clock line loads `sop_in ^ xor_in`.
- R3: With `cfg_ff_type` 1 (toggle), a rising edge loads the current stored value XOR (`sop_in ^ xor_in`).
- R4: With `cfg_ff_type` 2 (J-K, J = `sop_in`, K = `xor_in`), a rising edge loads (J & ~Q) | (~K & Q).
- R5: With `cfg_ff_type` 3 (set-reset, S = `sop_in`, R = `xor_in`), a rising edge works as follows:
  - S only loads 1.
  - R only loads 0.
  - Neither input, or both inputs together, keeps the stored value.
- R6: Only a rising edge on `clk_lines[cfg_clk_sel]` updates the stored value. Edges on the other clock lines leave it unchanged.
- R7: With `cfg_mode` 2 (latched), the element passes `sop_in ^ xor_in` while the selected clock line is high. It holds the last value while that line is low.
- R8: In registered and latched modes, a high level on `sr_lines[cfg_set_sel]` forces the stored value to 1 at once, without a clock. A selector value of 3 selects no line.
- R9: In registered and latched modes, a high level on `sr_lines[cfg_rst_sel]` forces the stored value to 0 at once. A selector value of 3 selects no line. Reset wins when set and reset are both active.
- R10: In every mode, `mc_out` equals `mc_fb` XOR `cfg_out_inv`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sop_in | input | 1 | Sum-of-products term (J or S input in J-K / set-reset types) |
| xor_in | input | 1 | XOR term (K or R input in J-K / set-reset types) |
| clk_lines | input | 4 | Shared per-block clock lines |
| sr_lines | input | 3 | Shared per-block set/reset lines, active high |
| cfg_mode | input | 2 | 0/3 combinatorial, 1 registered, 2 latched |
| cfg_ff_type | input | 2 | 0 D, 1 toggle, 2 J-K, 3 set-reset |
| cfg_clk_sel | input | 2 | Index of the clock line used |
| cfg_set_sel | input | 2 | Index of the set line, 3 = none |
| cfg_rst_sel | input | 2 | Index of the reset line, 3 = none |
| cfg_out_inv | input | 1 | Invert the pin-side output |
| mc_out | output | 1 | Polarity-adjusted macrocell output |
| mc_fb | output | 1 | True-polarity feedback to the routing array |

## Verification
The bench sweeps every flip-flop type against every clock line, both starting states and all four input pairs. A wrong next-state equation, such as a set-reset element that sets instead of holding when both inputs are high, shows up as a wrong stored bit. After each D load it pulses a clock line that is not selected, with inverted data. A selection mux decoded on the wrong bits would reload the element there.

The set and reset selectors are walked over every line and over the "none" code. A selector that lets code 3 through, or picks the wrong line, would force the element from an unselected line. The bench also holds set and reset high together, which catches swapped priority. Latch transparency and hold are checked by changing data on both phases of the selected line. Combinatorial mode is checked while clock and set lines toggle, which exposes a cell that still gates its output through the storage element.

// File: rtl/mc_pkg.sv
package mc_pkg;

   typedef enum logic [1:0] {
      MC_COMB     = 2'd0,
      MC_REG      = 2'd1,
      MC_LATCH    = 2'd2,
      MC_COMB_ALT = 2'd3
   } mc_mode_e;

   typedef enum logic [1:0] {
      FF_D  = 2'd0,
      FF_T  = 2'd1,
      FF_JK = 2'd2,
      FF_SR = 2'd3
   } mc_ff_e;

   localparam int unsigned MC_MODE_W = 2;
   localparam int unsigned MC_FF_W   = 2;

endpackage

// File: rtl/mc_line_select.sv
module mc_line_select #(
   parameter int unsigned N_LINES  = 4,
   parameter int unsigned SEL_W    = 2,
   parameter bit          HAS_NONE = 1'b0
) (
   input  logic [N_LINES-1:0] lines,
   input  logic [SEL_W-1:0]   sel,
   output logic               hit
);
   localparam int unsigned PAD_N = 1 << SEL_W;

   logic [PAD_N-1:0] pad;

   generate
      if (HAS_NONE) begin : g_chk_none
         if (N_LINES >= PAD_N) begin : g_bad
            $error("mc_line_select: no spare code for the none selection");
         end
      end else begin : g_chk_full
         if (N_LINES != PAD_N) begin : g_bad
            $error("mc_line_select: line count must fill the select field");
         end
      end

      for (genvar i = 0; i < PAD_N; i++) begin : g_pad
         if (i < N_LINES) begin : g_real
            assign pad[i] = lines[i];
         end else begin : g_none
            assign pad[i] = 1'b0;
         end
      end
   endgenerate

   assign hit = pad[sel];

endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
   import mc_pkg::*;
(
   input  logic   term_a,
   input  logic   term_b,
   input  logic   q_now,
   input  mc_ff_e ff_type,
   output logic   d_xor,
   output logic   d_reg
);
   assign d_xor = term_a ^ term_b;

   always_comb begin
      unique case (ff_type)
         FF_D:  d_reg = d_xor;
         FF_T:  d_reg = q_now ^ d_xor;
         FF_JK: d_reg = (term_a & ~q_now) | (~term_b & q_now);
         FF_SR: begin
            if (term_a && !term_b)      d_reg = 1'b1;
            else if (!term_a && term_b) d_reg = 1'b0;
            else                        d_reg = q_now;
         end
         default: d_reg = d_xor;
      endcase
   end

endmodule

// File: rtl/mc_store.sv
module mc_store #(
   parameter bit LATCH_EN = 1'b1
) (
   input  logic clk_hit,
   input  logic set_hit,
   input  logic rst_hit,
   input  logic d_reg,
   input  logic d_lat,
   output logic q_reg,
   output logic q_lat
);

   always_ff @(posedge clk_hit or posedge rst_hit or posedge set_hit) begin
      if (rst_hit)      q_reg <= 1'b0;
      else if (set_hit) q_reg <= 1'b1;
      else              q_reg <= d_reg;
   end

   generate
      if (LATCH_EN) begin : g_latch
         always_latch begin
            if (rst_hit)      q_lat = 1'b0;
            else if (set_hit) q_lat = 1'b1;
            else if (clk_hit) q_lat = d_lat;
         end
      end else begin : g_no_latch
         assign q_lat = d_lat;
      end
   endgenerate

endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
   import mc_pkg::*;
#(
   parameter int unsigned N_CLK    = 4,
   parameter int unsigned N_SR     = 3,
   parameter bit          LATCH_EN = 1'b1,
   localparam int unsigned CLK_W   = (N_CLK > 1) ? $clog2(N_CLK) : 1,
   localparam int unsigned SR_W    = $clog2(N_SR + 1)
) (
   input  logic                 sop_in,
   input  logic                 xor_in,
   input  logic [N_CLK-1:0]     clk_lines,
   input  logic [N_SR-1:0]      sr_lines,
   input  logic [MC_MODE_W-1:0] cfg_mode,
   input  logic [MC_FF_W-1:0]   cfg_ff_type,
   input  logic [CLK_W-1:0]     cfg_clk_sel,
   input  logic [SR_W-1:0]      cfg_set_sel,
   input  logic [SR_W-1:0]      cfg_rst_sel,
   input  logic                 cfg_out_inv,
   output logic                 mc_out,
   output logic                 mc_fb
);

   generate
      if (N_CLK < 2 || N_CLK != (1 << CLK_W)) begin : g_bad_clk
         $error("mc_macrocell: N_CLK must be a power of two, at least 2");
      end
      if (N_SR < 1) begin : g_bad_sr
         $error("mc_macrocell: N_SR must be at least 1");
      end
   endgenerate

   logic clk_hit, set_hit, rst_hit;
   logic d_xor, d_reg, q_reg, q_lat;
   mc_mode_e mode;

   assign mode = mc_mode_e'(cfg_mode);

   mc_line_select #(.N_LINES(N_CLK), .SEL_W(CLK_W), .HAS_NONE(1'b0)) u_clk_sel (
      .lines (clk_lines),
      .sel   (cfg_clk_sel),
      .hit   (clk_hit)
   );

   mc_line_select #(.N_LINES(N_SR), .SEL_W(SR_W), .HAS_NONE(1'b1)) u_set_sel (
      .lines (sr_lines),
      .sel   (cfg_set_sel),
      .hit   (set_hit)
   );

   mc_line_select #(.N_LINES(N_SR), .SEL_W(SR_W), .HAS_NONE(1'b1)) u_rst_sel (
      .lines (sr_lines),
      .sel   (cfg_rst_sel),
      .hit   (rst_hit)
   );

   mc_next_state u_next (
      .term_a  (sop_in),
      .term_b  (xor_in),
      .q_now   (q_reg),
      .ff_type (mc_ff_e'(cfg_ff_type)),
      .d_xor   (d_xor),
      .d_reg   (d_reg)
   );

   mc_store #(.LATCH_EN(LATCH_EN)) u_store (
      .clk_hit (clk_hit),
      .set_hit (set_hit),
      .rst_hit (rst_hit),
      .d_reg   (d_reg),
      .d_lat   (d_xor),
      .q_reg   (q_reg),
      .q_lat   (q_lat)
   );

   always_comb begin
      unique case (mode)
         MC_REG:   mc_fb = q_reg;
         MC_LATCH: mc_fb = q_lat;
         default:  mc_fb = d_xor;
      endcase
   end

   assign mc_out = mc_fb ^ cfg_out_inv;

endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk #(
   parameter int unsigned N_CLK = 4,
   parameter int unsigned N_SR  = 3,
   localparam int unsigned CLK_W = (N_CLK > 1) ? $clog2(N_CLK) : 1,
   localparam int unsigned SR_W  = $clog2(N_SR + 1),
   localparam int unsigned SR_PAD = 1 << SR_W
) (
   input logic              sop_in,
   input logic              xor_in,
   input logic [N_CLK-1:0]  clk_lines,
   input logic [N_SR-1:0]   sr_lines,
   input logic [1:0]        cfg_mode,
   input logic [1:0]        cfg_ff_type,
   input logic [CLK_W-1:0]  cfg_clk_sel,
   input logic [SR_W-1:0]   cfg_set_sel,
   input logic [SR_W-1:0]   cfg_rst_sel,
   input logic              cfg_out_inv,
   input logic              mc_out,
   input logic              mc_fb
);
   logic [SR_PAD-1:0] sr_pad;
   logic ck, set_act, rst_act, sr_any, comb_md;
   logic d_armed    = 1'b0;
   logic hold_armed = 1'b0;
   logic d_cap      = 1'b0;
   logic q_cap      = 1'b0;

   assign sr_pad  = SR_PAD'(sr_lines);
   assign ck      = clk_lines[cfg_clk_sel];
   assign set_act = sr_pad[cfg_set_sel];
   assign rst_act = sr_pad[cfg_rst_sel];
   assign sr_any  = set_act | rst_act;
   assign comb_md = (cfg_mode == 2'd0) || (cfg_mode == 2'd3);

   always_ff @(posedge ck) begin
      d_armed    <= (cfg_mode == 2'd1) && (cfg_ff_type == 2'd0) && !sr_any;
      hold_armed <= (cfg_mode == 2'd1) && (cfg_ff_type == 2'd3) && sop_in && xor_in && !sr_any;
      d_cap      <= sop_in ^ xor_in;
      q_cap      <= mc_fb;
   end

   // R1
   comb_follow_chk: assert property (@(negedge ck) disable iff (1'b0)
      comb_md |-> (mc_out == (sop_in ^ xor_in ^ cfg_out_inv)));

   // R2
   reg_d_load_chk: assert property (@(negedge ck) disable iff (sr_any)
      (d_armed && cfg_mode == 2'd1) |-> (mc_fb == d_cap));

   // R5
   sr_both_hold_chk: assert property (@(negedge ck) disable iff (sr_any)
      (hold_armed && cfg_mode == 2'd1) |-> (mc_fb == q_cap));

   // R7
   latch_pass_chk: assert property (@(negedge ck) disable iff (sr_any)
      (cfg_mode == 2'd2) |-> (mc_fb == (sop_in ^ xor_in)));

   // R8
   set_force_chk: assert property (@(negedge ck) disable iff (rst_act)
      (set_act && !comb_md) |-> mc_fb);

   // R9
   rst_force_chk: assert property (@(negedge ck) disable iff (1'b0)
      (rst_act && !comb_md) |-> !mc_fb);

endmodule

bind mc_macrocell mc_macrocell_chk #(.N_CLK(N_CLK), .N_SR(N_SR)) u_chk (
   .sop_in      (sop_in),
   .xor_in      (xor_in),
   .clk_lines   (clk_lines),
   .sr_lines    (sr_lines),
   .cfg_mode    (cfg_mode),
   .cfg_ff_type (cfg_ff_type),
   .cfg_clk_sel (cfg_clk_sel),
   .cfg_set_sel (cfg_set_sel),
   .cfg_rst_sel (cfg_rst_sel),
   .cfg_out_inv (cfg_out_inv),
   .mc_out      (mc_out),
   .mc_fb       (mc_fb)
);

// File: tb/mc_macrocell_bench.sv
module mc_macrocell_bench;

   logic       clk = 1'b0;
   logic       sop_in = 1'b0, xor_in = 1'b0;
   logic [3:0] clk_lines = '0;
   logic [2:0] sr_lines = '0;
   logic [1:0] cfg_mode = 2'd1, cfg_ff_type = 2'd0, cfg_clk_sel = 2'd0;
   logic [1:0] cfg_set_sel = 2'd3, cfg_rst_sel = 2'd0;
   logic       cfg_out_inv = 1'b0;
   logic       mc_out, mc_fb;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   mc_macrocell u_mc_macrocell (
      .sop_in      (sop_in),
      .xor_in      (xor_in),
      .clk_lines   (clk_lines),
      .sr_lines    (sr_lines),
      .cfg_mode    (cfg_mode),
      .cfg_ff_type (cfg_ff_type),
      .cfg_clk_sel (cfg_clk_sel),
      .cfg_set_sel (cfg_set_sel),
      .cfg_rst_sel (cfg_rst_sel),
      .cfg_out_inv (cfg_out_inv),
      .mc_out      (mc_out),
      .mc_fb       (mc_fb)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic pulse_clk(input int k);
      @(negedge clk) clk_lines[k] = 1'b1;
      @(negedge clk) clk_lines[k] = 1'b0;
   endtask

   task automatic pulse_sr(input int k);
      @(negedge clk) sr_lines[k] = 1'b1;
      @(negedge clk) sr_lines[k] = 1'b0;
   endtask

   function automatic logic next_q(input int ty, input logic q, input logic a, input logic b);
      case (ty)
         0: return a ^ b;
         1: return q ^ a ^ b;
         2: return (a & ~q) | (~b & q);
         default: return (a & ~b) ? 1'b1 : ((~a & b) ? 1'b0 : q);
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic e;
      string tg;

      // reset state: R9
      @(negedge clk) sr_lines[0] = 1'b1;
      @(posedge clk);
      check("R9 reset state fb", mc_fb, 1'b0);
      check("R10 reset state out", mc_out, 1'b0);
      @(negedge clk) sr_lines[0] = 1'b0;

      // registered sweep: R2 R3 R4 R5 R6 R10
      for (int cs = 0; cs < 4; cs++) begin
         for (int ty = 0; ty < 4; ty++) begin
            for (int q0 = 0; q0 < 2; q0++) begin
               for (int ab = 0; ab < 4; ab++) begin
                  @(negedge clk);
                  cfg_mode = 2'd1; cfg_ff_type = 2'(ty); cfg_clk_sel = 2'(cs);
                  cfg_set_sel = 2'd1; cfg_rst_sel = 2'd0;
                  cfg_out_inv = 1'(q0) ^ ab[0];
                  pulse_sr(q0 != 0 ? 1 : 0);
                  @(negedge clk) begin sop_in = ab[1]; xor_in = ab[0]; end
                  pulse_clk(cs);
                  @(posedge clk);
                  e = next_q(ty, 1'(q0), ab[1], ab[0]);
                  tg = (ty == 0) ? "R2" : (ty == 1) ? "R3" : (ty == 2) ? "R4" : "R5";
                  check(tg, mc_fb, e);
                  check("R10 registered out", mc_out, e ^ cfg_out_inv);
                  if (ty == 0) begin
                     @(negedge clk) begin sop_in = ~e; xor_in = 1'b0; end
                     pulse_clk((cs + 1) % 4);
                     @(posedge clk);
                     check("R6 unselected clock", mc_fb, e);
                  end
               end
            end
         end
      end

      // combinatorial: R1 R10
      for (int md = 0; md < 4; md += 3) begin
         for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            cfg_mode = 2'(md); cfg_clk_sel = 2'd2; cfg_set_sel = 2'd1; cfg_rst_sel = 2'd0;
            cfg_out_inv = v[2]; sop_in = v[1]; xor_in = v[0];
            @(posedge clk);
            check("R1 comb fb", mc_fb, v[1] ^ v[0]);
            check("R10 comb out", mc_out, v[1] ^ v[0] ^ v[2]);
            @(negedge clk) begin clk_lines[2] = 1'b1; sr_lines[1] = 1'b1; end
            @(posedge clk);
            check("R1 comb ignores clock/set", mc_fb, v[1] ^ v[0]);
            @(negedge clk) begin clk_lines[2] = 1'b0; sr_lines[1] = 1'b0; sr_lines[0] = 1'b1; end
            @(posedge clk);
            check("R1 comb ignores reset", mc_fb, v[1] ^ v[0]);
            @(negedge clk) sr_lines[0] = 1'b0;
         end
      end

      // latched: R7 R9 R10
      @(negedge clk);
      cfg_mode = 2'd2; cfg_clk_sel = 2'd3; cfg_set_sel = 2'd3; cfg_rst_sel = 2'd2;
      cfg_out_inv = 1'b1; sop_in = 1'b1; xor_in = 1'b0;
      @(negedge clk) clk_lines[3] = 1'b1;
      @(posedge clk);
      check("R7 latch open pass 1", mc_fb, 1'b1);
      check("R10 latch out", mc_out, 1'b0);
      @(negedge clk) xor_in = 1'b1;
      @(posedge clk);
      check("R7 latch open pass 0", mc_fb, 1'b0);
      @(negedge clk) sop_in = 1'b0;
      @(posedge clk);
      check("R7 latch open pass again", mc_fb, 1'b1);
      @(negedge clk) clk_lines[3] = 1'b0;
      @(negedge clk) sop_in = 1'b1;
      @(posedge clk);
      check("R7 latch closed hold", mc_fb, 1'b1);
      @(negedge clk) clk_lines[1] = 1'b1;
      @(posedge clk);
      check("R7 latch other line ignored", mc_fb, 1'b1);
      @(negedge clk) clk_lines[1] = 1'b0;
      pulse_sr(2);
      @(posedge clk);
      check("R9 latch reset", mc_fb, 1'b0);

      // set line select: R8
      for (int s = 0; s < 4; s++) begin
         for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            cfg_mode = 2'd1; cfg_ff_type = 2'd0; cfg_clk_sel = 2'd0;
            cfg_set_sel = 2'(s); cfg_rst_sel = 2'd3; sop_in = 1'b0; xor_in = 1'b0;
            pulse_clk(0);
            @(negedge clk) sr_lines[j] = 1'b1;
            @(posedge clk);
            check("R8 set select", mc_fb, (s == j) ? 1'b1 : 1'b0);
            @(negedge clk) sr_lines[j] = 1'b0;
         end
      end

      // reset line select: R9
      for (int s = 0; s < 4; s++) begin
         for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            cfg_mode = 2'd1; cfg_ff_type = 2'd0; cfg_clk_sel = 2'd1;
            cfg_set_sel = 2'd3; cfg_rst_sel = 2'(s); sop_in = 1'b1; xor_in = 1'b0;
            pulse_clk(1);
            @(negedge clk) sr_lines[j] = 1'b1;
            @(posedge clk);
            check("R9 reset select", mc_fb, (s == j) ? 1'b0 : 1'b1);
            @(negedge clk) sr_lines[j] = 1'b0;
         end
      end

      // priority and clock blocked under reset: R9
      @(negedge clk);
      cfg_mode = 2'd1; cfg_ff_type = 2'd0; cfg_clk_sel = 2'd0;
      cfg_set_sel = 2'd1; cfg_rst_sel = 2'd2; sop_in = 1'b1; xor_in = 1'b0;
      @(negedge clk) begin sr_lines[1] = 1'b1; sr_lines[2] = 1'b1; end
      @(posedge clk);
      check("R9 reset beats set", mc_fb, 1'b0);
      @(negedge clk) sr_lines[1] = 1'b0;
      pulse_clk(0);
      @(posedge clk);
      check("R9 reset holds through clock", mc_fb, 1'b0);
      @(negedge clk) sr_lines[2] = 1'b0;
      @(posedge clk);
      check("R9 released stays low", mc_fb, 1'b0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule